// File: doc/BRIEF.md
# Line-to-Block Reordering Buffer

This block sits between a raster video source and a block-based transform frontend. The source delivers pixels one per clock in line order. The block collects eight consecutive lines into a stripe buffer. It then streams that stripe out one pixel per clock as 8x8 tiles, left to right. Inside a tile the order is row-major. Each tile is played out three times back to back before the next tile starts, so that three frontend passes can consume the same data.

Four stripe buffers are used in rotation, so filling and draining overlap on the one clock that the source and the frontend share. Draining a stripe takes three times as long as filling it. The block therefore raises a stop signal when every buffer holds unread data. It keeps stop raised until the frontend has drained three stripes. Once a stripe is complete the output runs without gaps. When no complete stripe is waiting, the valid output falls instead of repeating old data.

Top module: `line_block_reorder`

## Requirements
- R1: After a synchronous active-high reset, outValid, outFirst and stop are low and all four buffers count as empty.
- R2: Pixels of a stripe leave tile by tile from left to right. Inside a tile the order is row 0 columns 0..7, then row 1, and so on, where row r column c of tile t is the pixel at raster position r*IMG_W + t*8 + c of that stripe. Stripes leave in the order they were written.
- R3: Each tile is emitted three consecutive times (64 samples per pass) before the next tile begins.
- R4: outFirst is high exactly on the first sample of every 64-sample pass and is low on all other cycles.
- R5: No sample is emitted for a stripe until all IMG_W*8 of its pixels have been accepted.
- R6: The first sample of a stripe appears two clock edges after the edge that accepts its last pixel, or directly after the previous stripe if that one is still draining. While a complete unread stripe exists, outValid is high on every cycle.
- R7: When no complete unread stripe remains, outValid goes low on the cycle after the last sample of the final replay.
- R8: stop rises on the clock edge at which a fourth complete unread stripe is stored.
- R9: Once raised, stop falls on the edge at which the frontend finishes the third stripe since stop rose, and not before.
- R10: A pixel presented with inValid high while stop is high is discarded and never appears at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by source, block and frontend |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Source pixel present on inData |
| inData | input | DATA_W | Source pixel, raster order |
| outValid | output | 1 | outData carries a tile sample |
| outData | output | DATA_W | Tile sample to the frontend |
| outFirst | output | 1 | First sample of a 64-sample pass |
| stop | output | 1 | Source must hold off while high |

## Verification
A pixel accepted on one edge can reach the output at the earliest on the second edge after that. This is one edge to mark the stripe full and one for the registered memory read. stop moves on the same edge that changes the count of full stripes. The bench samples one nanosecond after each rising edge and models both rules exactly. Its expected outValid for a sample uses the stripe count known one edge earlier, while its expected stop uses the count after the current edge. Every output sample is popped from a scoreboard filled by the driver at the moment it presents a stripe's final pixel. This gives cycle-exact checks of continuity, the dry-run drop and the stop window.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

  // Strobes passed from the control unit to the storage datapath
  typedef struct packed {
    logic wrEn;     // store inData at wrAddr
    logic rdEn;     // fetch rdAddr, output valid next cycle
    logic rdFirst;  // fetched sample opens a 64-sample pass
  } lbr_strobe_t;

endpackage

// File: rtl/lbr_ctrl.sv
module lbr_ctrl
  import lbr_pkg::*;
#(
  parameter int IMG_W   = 32,
  parameter int BLK_DIM = 8,
  parameter int NBUF    = 4,
  parameter int REPLAY  = 3,
  parameter int RESUME  = 3,
  parameter int AW      = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output lbr_strobe_t   strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          stop
);

  localparam int STRIPE  = IMG_W * BLK_DIM;
  localparam int BLK_ROW = IMG_W / BLK_DIM;
  localparam int SW      = $clog2(STRIPE);
  localparam int BW      = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam int DW      = (BLK_DIM > 1) ? $clog2(BLK_DIM) : 1;
  localparam int KW      = (BLK_ROW > 1) ? $clog2(BLK_ROW) : 1;
  localparam int PW      = (REPLAY > 1) ? $clog2(REPLAY) : 1;
  localparam int FW      = $clog2(NBUF + 1);
  localparam int CW      = $clog2(RESUME + 1);

  localparam logic [SW-1:0] WR_LAST   = SW'(STRIPE - 1);
  localparam logic [BW-1:0] BUF_LAST  = BW'(NBUF - 1);
  localparam logic [DW-1:0] DIM_LAST  = DW'(BLK_DIM - 1);
  localparam logic [KW-1:0] BLK_LAST  = KW'(BLK_ROW - 1);
  localparam logic [PW-1:0] PASS_LAST = PW'(REPLAY - 1);
  localparam logic [FW-1:0] FILL_MAX  = FW'(NBUF);
  localparam logic [CW-1:0] REL_LAST  = CW'(RESUME - 1);

  logic [BW-1:0] wrBuf, rdBuf;
  logic [SW-1:0] wrIdx;
  logic [KW-1:0] rdBlk;
  logic [PW-1:0] rdPass;
  logic [DW-1:0] rdRow, rdCol;
  logic [FW-1:0] fillCnt, fillNext;
  logic [CW-1:0] relCnt;
  logic          stopReg;
  logic          wrAccept, wrDone, rdEn, rdLast;

  function automatic logic [BW-1:0] nextBuf(input logic [BW-1:0] b);
    return (b == BUF_LAST) ? '0 : b + 1'b1;
  endfunction

  always_comb begin
    wrAccept = inValid && !stopReg;
    wrDone   = wrAccept && (wrIdx == WR_LAST);
    rdEn     = (fillCnt != '0);
    rdLast   = rdEn && (rdCol == DIM_LAST) && (rdRow == DIM_LAST) &&
               (rdPass == PASS_LAST) && (rdBlk == BLK_LAST);
    fillNext = fillCnt + FW'(wrDone) - FW'(rdLast);

    strobe.wrEn    = wrAccept;
    strobe.rdEn    = rdEn;
    strobe.rdFirst = rdEn && (rdRow == '0) && (rdCol == '0);

    wrAddr = AW'(wrBuf) * AW'(STRIPE) + AW'(wrIdx);
    rdAddr = AW'(rdBuf) * AW'(STRIPE) + AW'(rdRow) * AW'(IMG_W) +
             AW'(rdBlk) * AW'(BLK_DIM) + AW'(rdCol);
    stop   = stopReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrBuf   <= '0;
      wrIdx   <= '0;
      rdBuf   <= '0;
      rdBlk   <= '0;
      rdPass  <= '0;
      rdRow   <= '0;
      rdCol   <= '0;
      fillCnt <= '0;
      relCnt  <= '0;
      stopReg <= 1'b0;
    end else begin
      fillCnt <= fillNext;

      // fill side: raster index within the current stripe
      if (wrAccept) begin
        if (wrIdx == WR_LAST) begin
          wrIdx <= '0;
          wrBuf <= nextBuf(wrBuf);
        end else begin
          wrIdx <= wrIdx + 1'b1;
        end
      end

      // drain side: column, row, pass, tile, buffer
      if (rdEn) begin
        if (rdCol != DIM_LAST) begin
          rdCol <= rdCol + 1'b1;
        end else begin
          rdCol <= '0;
          if (rdRow != DIM_LAST) begin
            rdRow <= rdRow + 1'b1;
          end else begin
            rdRow <= '0;
            if (rdPass != PASS_LAST) begin
              rdPass <= rdPass + 1'b1;
            end else begin
              rdPass <= '0;
              if (rdBlk != BLK_LAST) begin
                rdBlk <= rdBlk + 1'b1;
              end else begin
                rdBlk <= '0;
                rdBuf <= nextBuf(rdBuf);
              end
            end
          end
        end
      end

      // backpressure with hysteresis
      if (!stopReg && (fillNext == FILL_MAX)) begin
        stopReg <= 1'b1;
        relCnt  <= '0;
      end else if (stopReg && rdLast) begin
        if (relCnt == REL_LAST) stopReg <= 1'b0;
        relCnt <= relCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lbr_store.sv
module lbr_store
  import lbr_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 1024,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  lbr_strobe_t       strobe,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outFirst
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrAddr] <= inData;
    if (strobe.rdEn) outData <= mem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outFirst <= 1'b0;
    end else begin
      outValid <= strobe.rdEn;
      outFirst <= strobe.rdFirst;
    end
  end

endmodule

// File: rtl/line_block_reorder.sv
module line_block_reorder
  import lbr_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int IMG_W   = 32,
  parameter int BLK_DIM = 8,
  parameter int NBUF    = 4,
  parameter int REPLAY  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outFirst,
  output logic              stop
);

  localparam int DEPTH  = NBUF * IMG_W * BLK_DIM;
  localparam int AW     = $clog2(DEPTH);
  localparam int RESUME = NBUF - 1;

  lbr_strobe_t   strobe;
  logic [AW-1:0] wrAddr, rdAddr;

  lbr_ctrl #(
    .IMG_W(IMG_W), .BLK_DIM(BLK_DIM), .NBUF(NBUF),
    .REPLAY(REPLAY), .RESUME(RESUME), .AW(AW)
  ) i_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .stop(stop)
  );

  lbr_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)
  ) i_store (
    .clk(clk), .rst(rst), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inData(inData), .outData(outData), .outValid(outValid), .outFirst(outFirst)
  );

endmodule

// File: rtl/lbr_checker.sv
module lbr_checker #(
  parameter int BLK_DIM = 8
) (
  input logic clk,
  input logic rst,
  input logic outValid,
  input logic outFirst,
  input logic stop
);

  localparam int PASS_LEN = BLK_DIM * BLK_DIM;
  localparam int PW = $clog2(PASS_LEN);
  localparam logic [PW-1:0] POS_LAST = PW'(PASS_LEN - 1);

  logic [PW-1:0] passPos;

  always_ff @(posedge clk) begin
    if (rst) passPos <= '0;
    else if (outValid) passPos <= (passPos == POS_LAST) ? '0 : passPos + 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && !stop && !outFirst));

  assert_first_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outFirst == (passPos == '0)));

  assert_first_needs_valid_R4: assert property (@(posedge clk) disable iff (rst)
    outFirst |-> outValid);

  assert_no_gap_in_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && (passPos != POS_LAST)) |=> outValid);

  assert_stop_rise_busy_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(stop) |-> outValid);

  assert_stop_fall_busy_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(stop) |-> outValid);

endmodule

bind line_block_reorder lbr_checker #(.BLK_DIM(BLK_DIM)) i_lbrChecker (
  .clk(clk), .rst(rst), .outValid(outValid), .outFirst(outFirst), .stop(stop)
);

// File: tb/test_line_block_reorder.sv
`timescale 1ns/1ps
module test_line_block_reorder;

  localparam int DATA_W = 12;
  localparam int IMG_W  = 32;
  localparam int BLK    = 8;
  localparam int STRIPE = IMG_W * BLK;
  localparam int BLKS   = IMG_W / BLK;
  localparam int REPLAY = 3;
  localparam int NBUF   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic outValid, outFirst, stop;
  logic [DATA_W-1:0] outData;

  always #2.5 clk = ~clk;

  line_block_reorder #(.DATA_W(DATA_W), .IMG_W(IMG_W), .BLK_DIM(BLK),
                       .NBUF(NBUF), .REPLAY(REPLAY)) i_line_block_reorder (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData), .outFirst(outFirst), .stop(stop)
  );

  typedef struct packed {
    logic [DATA_W-1:0] d;
    logic              f;
    logic [1:0]        pass;
  } exp_t;

  exp_t expQ[$];
  logic [DATA_W-1:0] stripeBuf [STRIPE];
  int checks = 0, fails = 0;
  int pushedNow = 0, prevPushed = 0, consumed = 0, posInStripe = 0;
  int seq = 0, wrPos = 0, relM = 0;
  bit stopM = 0, monOn = 0, sawStop = 0, sawResume = 0, done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // expected order of one stripe: tile, pass, row, column
  task automatic pushStripe();
    for (int t = 0; t < BLKS; t++)
      for (int p = 0; p < REPLAY; p++)
        for (int r = 0; r < BLK; r++)
          for (int c = 0; c < BLK; c++) begin
            exp_t e;
            e.d = stripeBuf[r*IMG_W + t*BLK + c];
            e.f = (r == 0) && (c == 0);
            e.pass = 2'(p);
            expQ.push_back(e);
          end
  endtask

  // driver: n accepted pixels, optional idle every gapEvery slots,
  // optional junk presented while stop is high (R10)
  task automatic drive(input int n, input int gapEvery, input bit poison);
    int acc = 0;
    int k = 0;
    while (acc < n) begin
      @(negedge clk);
      k++;
      if (stop) begin
        inValid = poison;
        inData  = '1;
      end else if (gapEvery != 0 && (k % gapEvery) == 0) begin
        inValid = 1'b0;
      end else begin
        inValid = 1'b1;
        inData  = DATA_W'(seq);
        stripeBuf[wrPos] = inData;
        seq++;
        wrPos++;
        acc++;
        if (wrPos == STRIPE) begin
          wrPos = 0;
          pushStripe();
          pushedNow++;
        end
      end
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // monitor: one nanosecond after every rising edge
  always @(posedge clk) begin
    bit released;
    bit expValid;
    int fillNow;
    #1;
    if (monOn) begin
      released = 0;
      expValid = (prevPushed - consumed) > 0;
      check(outValid == expValid, expValid ? "R6" : (consumed == prevPushed && wrPos != 0 ? "R5" : "R7"),
            "outValid", int'(outValid), int'(expValid));
      if (outValid) begin
        check(outData != '1, "R10", "discarded pixel emitted", int'(outData), 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R2", "unexpected sample", int'(outData), -1);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          if (e.pass == 2'd0)
            check(outData == e.d, "R2", "tile sample", int'(outData), int'(e.d));
          else
            check(outData == e.d, "R3", "replayed sample", int'(outData), int'(e.d));
          check(outFirst == e.f, "R4", "outFirst", int'(outFirst), int'(e.f));
        end
        posInStripe++;
        if (posInStripe == STRIPE * REPLAY) begin
          posInStripe = 0;
          consumed++;
          released = 1;
        end
      end else begin
        check(outFirst == 1'b0, "R4", "outFirst while idle", int'(outFirst), 0);
      end
      fillNow = pushedNow - consumed;
      if (!stopM && fillNow == NBUF) begin
        stopM = 1;
        relM = 0;
      end else if (stopM && released) begin
        relM++;
        if (relM == NBUF - 1) begin
          stopM = 0;
          sawResume = 1;
        end
      end
      check(stop == stopM, stopM ? "R8" : "R9", "stop", int'(stop), int'(stopM));
      if (stop) sawStop = 1;
      prevPushed = pushedNow;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    monOn = 1'b1;
    @(negedge clk);
    check(!outValid && !stop && !outFirst, "R1", "outputs after reset",
          int'({outValid, outFirst, stop}), 0);

    // partial stripe is held back (R5), then completed and drained dry (R7)
    drive(STRIPE - 1, 0, 1'b0);
    repeat (20) @(negedge clk);
    check(outValid == 1'b0, "R5", "valid on partial stripe", int'(outValid), 0);
    drive(1, 0, 1'b0);
    repeat (STRIPE * REPLAY + 20) @(negedge clk);
    check(outValid == 1'b0, "R7", "valid after drain", int'(outValid), 0);
    check(expQ.size() == 0, "R2", "pending after first stripe", expQ.size(), 0);

    // back-to-back stripes with junk during stop (R8, R9, R10)
    drive(6 * STRIPE, 0, 1'b1);
    // stripes with source gaps
    drive(2 * STRIPE, 3, 1'b0);

    for (int w = 0; w < 20000 && expQ.size() != 0; w++) @(negedge clk);
    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R2", "samples never emitted", expQ.size(), 0);
    check(outValid == 1'b0, "R7", "valid after final drain", int'(outValid), 0);
    check(sawStop, "R8", "stop ever raised", int'(sawStop), 1);
    check(sawResume, "R9", "stop released", int'(sawResume), 1);
    check(stop == 1'b0, "R9", "stop at end", int'(stop), 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog expired: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule